// File: doc/BRIEF.md
# Memory controller register stub

This block takes the place of a DRAM controller's configuration registers while a chip is being brought up. Firmware that starts initialisation, data training or impedance calibration sees each operation reported as complete at once, so boot code can run before any real memory interface exists. There is no timing, PHY or training logic inside.

The block sits on a simple bus with separate read and write strobes, a byte address into a 4 KiB window, and 32-bit write and read data. Only aligned 32-bit accesses are meaningful, and data is little-endian. Three registers are implemented: a control register, a calibration control register and a calibration status register. Address bits [1:0] are ignored. Any other offset below 0x2E4 is reported as unimplemented. Offsets from 0x2E4 to the top of the window are reported as out of range. A small response state machine records the kind of access just made and drives the registered read data and the two one-cycle flags.

The state machine has five states. ST_IDLE: no access. ST_READ_OK: an implemented register was read. ST_WRITE_OK: an implemented register was written. ST_UNIMPL: an unimplemented offset was accessed. ST_RANGE: an out-of-range offset was accessed. Every clock edge moves to the state chosen by that cycle's strobes and address. No strobe leads to ST_IDLE. A write strobe leads to ST_WRITE_OK, ST_UNIMPL or ST_RANGE. A read strobe with no write leads to ST_READ_OK, ST_UNIMPL or ST_RANGE. The synchronous reset forces ST_IDLE.

Top module: `memctl_reg_stub`

## Requirements
- R1: A synchronous active-high reset loads these values: control (offset 0x000) 0x80020000, calibration control (offset 0x0A8) 0x07B00000, calibration status (offset 0x0B0) 0x80000000. After reset, read data is zero and both flags are low.
- R2: A write to the control register stores bits 31 (start initialisation) and 30 (start data training) as 0. All other written bits are stored unchanged.
- R3: A write to the calibration control register stores the written word and sets bit 31 (calibration done) of the status register. The other status bits keep their values.
- R4: A write to the calibration status register stores the written word as given.
- R5: Read data for a read strobe appears in the next cycle. Address bits [1:0] do not affect register selection. In any cycle that follows no read, read data is zero.
- R6: An access to an offset below 0x2E4 that is not one of the three registers reads as zero and raises `unimpl_pulse` for exactly the next cycle. A write there changes no register.
- R7: An access to an offset from 0x2E4 to 0xFFF reads as zero and raises `range_pulse` for exactly the next cycle. A write there changes no register.
- R8: If the read and write strobes are both high, only the write is performed, and the read data in the next cycle is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| range_pulse | output | 1 | One-cycle flag for an out-of-range access |
| unimpl_pulse | output | 1 | One-cycle flag for an unimplemented offset |

## Verification
Every result is due exactly one clock edge after its strobe. Read data and both flags come out of the response state machine's registers, and a written register value becomes visible to a read issued on the following cycle. The bench drives each access just after a falling edge. It samples the outputs at the next falling edge, which is half a period after the capturing rising edge. The effects of a write are checked through a separate read in a later cycle, never in the write's own cycle.

// File: rtl/memctl_stub_pkg.sv
package memctl_stub_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CAL   = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h0B0;
    localparam logic [ADDR_W-1:0] OFS_LIMIT = 12'h2E4;

    localparam logic [DATA_W-1:0] RST_CTRL = 32'h8002_0000;
    localparam logic [DATA_W-1:0] RST_CAL  = 32'h07B0_0000;
    localparam logic [DATA_W-1:0] RST_STAT = 32'h8000_0000;

    localparam int BIT_INIT_GO  = 31;
    localparam int BIT_TRAIN_GO = 30;
    localparam int BIT_CAL_DONE = 31;

    typedef enum logic [2:0] {
        RG_CTRL,
        RG_CAL,
        RG_STAT,
        RG_UNIMPL,
        RG_RANGE
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_OK,
        ST_WRITE_OK,
        ST_UNIMPL,
        ST_RANGE
    } resp_state_e;

endpackage

// File: rtl/memctl_stub_decode.sv
module memctl_stub_decode
    import memctl_stub_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);

    localparam int WI_W = AW - 2;
    localparam logic [WI_W-1:0] WI_CTRL  = WI_W'(OFS_CTRL  >> 2);
    localparam logic [WI_W-1:0] WI_CAL   = WI_W'(OFS_CAL   >> 2);
    localparam logic [WI_W-1:0] WI_STAT  = WI_W'(OFS_STAT  >> 2);
    localparam logic [WI_W-1:0] WI_LIMIT = WI_W'(OFS_LIMIT >> 2);

    logic [WI_W-1:0] word_idx;
    assign word_idx = addr[AW-1:2];

    always_comb begin
        if (word_idx >= WI_LIMIT)
            region = RG_RANGE;
        else if (word_idx == WI_CTRL)
            region = RG_CTRL;
        else if (word_idx == WI_CAL)
            region = RG_CAL;
        else if (word_idx == WI_STAT)
            region = RG_STAT;
        else
            region = RG_UNIMPL;
    end

endmodule

// File: rtl/memctl_stub_regs.sv
module memctl_stub_regs
    import memctl_stub_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  region_e       region,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] cal_q,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] rd_val
);

    localparam logic [DW-1:0] GO_MASK = (DW'(1) << BIT_INIT_GO) | (DW'(1) << BIT_TRAIN_GO);
    localparam logic [DW-1:0] DONE_BIT = DW'(1) << BIT_CAL_DONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RST_CTRL;
            cal_q  <= RST_CAL;
            stat_q <= RST_STAT;
        end else if (wr_en) begin
            unique case (region)
                RG_CTRL: ctrl_q <= wdata & ~GO_MASK;
                RG_CAL: begin
                    cal_q  <= wdata;
                    stat_q <= stat_q | DONE_BIT;
                end
                RG_STAT: stat_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (region)
            RG_CTRL: rd_val = ctrl_q;
            RG_CAL:  rd_val = cal_q;
            RG_STAT: rd_val = stat_q;
            default: rd_val = '0;
        endcase
    end

endmodule

// File: rtl/memctl_stub_resp.sv
module memctl_stub_resp
    import memctl_stub_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  logic          wr,
    input  region_e       region,
    input  logic [DW-1:0] rd_val,
    output logic [DW-1:0] rdata,
    output logic          range_flag,
    output logic          unimpl_flag
);

    resp_state_e state_q, state_d;
    logic [DW-1:0] rdata_q;

    always_comb begin
        state_d = ST_IDLE;
        if (wr || rd) begin
            unique case (region)
                RG_UNIMPL: state_d = ST_UNIMPL;
                RG_RANGE:  state_d = ST_RANGE;
                default:   state_d = wr ? ST_WRITE_OK : ST_READ_OK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (state_d == ST_READ_OK) ? rd_val : '0;
        end
    end

    always_comb begin
        rdata       = '0;
        range_flag  = 1'b0;
        unimpl_flag = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_READ_OK:  rdata = rdata_q;
            ST_WRITE_OK: ;
            ST_UNIMPL:   unimpl_flag = 1'b1;
            ST_RANGE:    range_flag  = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/memctl_reg_stub.sv
module memctl_reg_stub
    import memctl_stub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              range_pulse,
    output logic              unimpl_pulse
);

    region_e           region;
    logic [DATA_W-1:0] ctrl_q, cal_q, stat_q, rd_val;

    memctl_stub_decode #(.AW(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .region (region)
    );

    memctl_stub_regs #(.DW(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .region (region),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .cal_q  (cal_q),
        .stat_q (stat_q),
        .rd_val (rd_val)
    );

    memctl_stub_resp #(.DW(DATA_W)) u_resp (
        .clk         (clk),
        .rst         (rst),
        .rd          (bus_rd),
        .wr          (bus_wr),
        .region      (region),
        .rd_val      (rd_val),
        .rdata       (bus_rdata),
        .range_flag  (range_pulse),
        .unimpl_flag (unimpl_pulse)
    );

endmodule

// File: rtl/memctl_reg_stub_chk.sv
module memctl_reg_stub_chk
    import memctl_stub_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              range_pulse,
    input logic              unimpl_pulse,
    input region_e           region,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] cal_q,
    input logic [DATA_W-1:0] stat_q
);

    AST_CTRL_GO_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && region == RG_CTRL) |=> (ctrl_q[31:30] == 2'b00 && ctrl_q[29:0] == $past(bus_wdata[29:0]))); // R2

    AST_CAL_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && region == RG_CAL) |=> (stat_q[31] && stat_q[30:0] == $past(stat_q[30:0]) && cal_q == $past(bus_wdata))); // R3

    AST_STAT_STORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && region == RG_STAT) |=> (stat_q == $past(bus_wdata))); // R4

    AST_RDATA_ZERO_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !bus_wr) |=> (bus_rdata == '0 && !range_pulse && !unimpl_pulse)); // R5

    AST_UNIMPL_PULSE: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && region == RG_UNIMPL) |=> (unimpl_pulse && !range_pulse && bus_rdata == '0)); // R6

    AST_UNIMPL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && region == RG_UNIMPL) |=> ($stable(ctrl_q) && $stable(cal_q) && $stable(stat_q))); // R6

    AST_RANGE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && region == RG_RANGE) |=> (range_pulse && !unimpl_pulse && bus_rdata == '0)); // R7

    AST_RANGE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && region == RG_RANGE) |=> ($stable(ctrl_q) && $stable(cal_q) && $stable(stat_q))); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_rd) |=> (bus_rdata == '0)); // R8

endmodule

bind memctl_reg_stub memctl_reg_stub_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .range_pulse  (range_pulse),
    .unimpl_pulse (unimpl_pulse),
    .region       (region),
    .ctrl_q       (ctrl_q),
    .cal_q        (cal_q),
    .stat_q       (stat_q)
);

// File: tb/memctl_reg_stub_tb.sv
`timescale 1ns/1ps
module memctl_reg_stub_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        range_pulse, unimpl_pulse;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    memctl_reg_stub u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .range_pulse  (range_pulse),
        .unimpl_pulse (unimpl_pulse)
    );

    // op: 1 read, 2 write; flags {range, unimpl}
    // fields: op[83:82] req[81:78] addr[77:66] data[65:34] exp[33:2] flags[1:0]
    localparam int NV = 18;
    localparam logic [83:0] VEC [NV] = '{
        {2'd1, 4'd1, 12'h000, 32'h0,        32'h8002_0000, 2'b00}, // R1
        {2'd1, 4'd1, 12'h0A8, 32'h0,        32'h07B0_0000, 2'b00}, // R1
        {2'd1, 4'd1, 12'h0B0, 32'h0,        32'h8000_0000, 2'b00}, // R1
        {2'd2, 4'd2, 12'h000, 32'hC001_2345, 32'h0,        2'b00}, // R2
        {2'd1, 4'd2, 12'h000, 32'h0,        32'h0001_2345, 2'b00}, // R2
        {2'd2, 4'd2, 12'h000, 32'h7FFF_FFFF, 32'h0,        2'b00}, // R2
        {2'd1, 4'd5, 12'h003, 32'h0,        32'h3FFF_FFFF, 2'b00}, // R5
        {2'd2, 4'd4, 12'h0B0, 32'h0000_1234, 32'h0,        2'b00}, // R4
        {2'd1, 4'd4, 12'h0B2, 32'h0,        32'h0000_1234, 2'b00}, // R4
        {2'd2, 4'd3, 12'h0A8, 32'h0000_ABCD, 32'h0,        2'b00}, // R3
        {2'd1, 4'd3, 12'h0B0, 32'h0,        32'h8000_1234, 2'b00}, // R3
        {2'd1, 4'd3, 12'h0A8, 32'h0,        32'h0000_ABCD, 2'b00}, // R3
        {2'd1, 4'd6, 12'h004, 32'h0,        32'h0,         2'b01}, // R6
        {2'd2, 4'd6, 12'h0AC, 32'hFFFF_FFFF, 32'h0,        2'b01}, // R6
        {2'd1, 4'd7, 12'h2E4, 32'h0,        32'h0,         2'b10}, // R7
        {2'd2, 4'd7, 12'hFFC, 32'hFFFF_FFFF, 32'h0,        2'b10}, // R7
        {2'd1, 4'd6, 12'h0A8, 32'h0,        32'h0000_ABCD, 2'b00}, // R6 R7 writes left cal alone
        {2'd1, 4'd7, 12'h000, 32'h0,        32'h3FFF_FFFF, 2'b00}  // R7 ctrl unchanged
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    // Drive one access after a falling edge, then sample at the next falling edge.
    task automatic access(input logic rd, input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs after reset
        check(1, bus_rdata, 32'h0, "rdata after reset");
        check(1, {30'b0, range_pulse, unimpl_pulse}, 32'h0, "flags after reset");

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][83:82] == 2'd1, VEC[i][83:82] == 2'd2, VEC[i][77:66], VEC[i][65:34]);
            check(int'(VEC[i][81:78]), {30'b0, range_pulse, unimpl_pulse}, {30'b0, VEC[i][1:0]}, "flags");
            if (VEC[i][83:82] == 2'd1)
                check(int'(VEC[i][81:78]), bus_rdata, VEC[i][33:2], "read data");
        end

        // R5: idle cycle after a read returns zero data and no flags
        access(1'b1, 1'b0, 12'h0A8, 32'h0);
        @(negedge clk);
        check(5, bus_rdata, 32'h0, "rdata in idle cycle");
        check(5, {30'b0, range_pulse, unimpl_pulse}, 32'h0, "flags in idle cycle");

        // R6: flag lasts only one cycle
        access(1'b1, 1'b0, 12'h100, 32'h0);
        check(6, {31'b0, unimpl_pulse}, 32'h1, "unimpl pulse high");
        @(negedge clk);
        check(6, {31'b0, unimpl_pulse}, 32'h0, "unimpl pulse one cycle");

        // R8: simultaneous read and write
        access(1'b1, 1'b1, 12'h000, 32'h0000_0055);
        check(8, bus_rdata, 32'h0, "rdata with both strobes");
        access(1'b1, 1'b0, 12'h000, 32'h0);
        check(8, bus_rdata, 32'h0000_0055, "write performed with both strobes");

        // R1: reset mid-run restores values
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(1'b1, 1'b0, 12'h0B0, 32'h0);
        check(1, bus_rdata, 32'h8000_0000, "status after second reset");
        access(1'b1, 1'b0, 12'h000, 32'h0);
        check(1, bus_rdata, 32'h8002_0000, "control after second reset");
        access(1'b1, 1'b0, 12'h0A8, 32'h0);
        check(1, bus_rdata, 32'h07B0_0000, "cal control after second reset");

        finish_run();
    end

endmodule